// File: doc/BRIEF.md
# Writeback Bus Reservation Table

This block decides, at issue time, whether a fixed-latency instruction may be sent to execution without colliding with another result on a single shared writeback bus. It keeps one busy bit for every future bus cycle. Bit k stands for the bus cycle k clocks from now, and bit 0 is the current cycle. The whole vector moves one position toward bit 0 on every clock.

Each candidate port gives a latency L. The block grants the candidate when bit L is clear, which means nobody has claimed the bus in the cycle when this instruction would write back. When the issue logic accepts one granted candidate, the block claims that future cycle. Because the shift happens on the same edge, the claim lands at bit L-1 of the shifted vector.

Several candidates with different latencies are checked in parallel. Only the one named by the select input can reserve a slot in a given cycle. Operations whose latency is not known at issue, such as memory accesses, must not use this block.

Top module: `wb_resv_table`

## Requirements
- R1: A synchronous active-low reset clears every busy bit. An accept presented while reset is low reserves nothing.
- R2: `cand_grant[i]` is 1 exactly when `cand_valid[i]` is 1, the latency L of that candidate lies in 1..DEPTH-1, and `busy_vec[L]` is 0. Bit k of `busy_vec` marks the bus cycle k clocks ahead, and bit 0 is the current cycle.
- R3: On every clock out of reset, the new `busy_vec[k]` takes the old `busy_vec[k+1]`, and the top bit fills with 0.
- R4: When `issue_accept` is 1 and the selected candidate is granted with latency L, `busy_vec[L-1]` is 1 after the edge, on top of the shift.
- R5: When `issue_accept` is 0, or the selected candidate is not granted, the edge only shifts `busy_vec` and sets no bit.
- R6: A latency of 0 is never granted.
- R7: Candidates are checked independently in the same cycle. `issue_sel` is the candidate index: 0 picks `cand_lat[LAT_W-1:0]`, 1 picks the next field up. Only the selected candidate reserves.
- R8: The longest latency, DEPTH-1, can be reserved, and it appears at `busy_vec[DEPTH-2]` after the edge.
- R9: The following sequence grants the first five issues and refuses the sixth:
  - a latency-10 issue at cycle 0;
  - latency-5 issues at cycles 1 to 4;
  - a latency-5 candidate at cycle 5, which is refused because it would complete at cycle 10, already claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | NCAND | One valid flag per candidate |
| cand_lat | input | NCAND*LAT_W | Packed latencies, candidate 0 in the lowest field |
| issue_accept | input | 1 | Issue logic accepts the selected candidate this cycle |
| issue_sel | input | SEL_W | Index of the candidate being accepted |
| cand_grant | output | NCAND | Per-candidate grant, 0 means conflict |
| busy_vec | output | DEPTH | Busy bit for each future bus cycle |

## Verification
The bench replays the add-after-multiply conflict. A table that indexes one slot off, or that forgets the shift on a reserving edge, grants the sixth add and double-books cycle 10. It presents latency 0 and the longest latency: an off-by-one decode either grants latency 0 or drops the top reservation. It also presents two granted candidates together and accepts one of them, an accept on a refused candidate, and an accept during reset. A design that reserves for the wrong port, or ignores the grant or the reset, leaves extra busy bits that the model comparison on each clock flags.

// File: rtl/wb_resv_pkg.sv
// Shared helpers for the writeback reservation table.
// Assumes latencies are unsigned and that a latency of 0 is meaningless.
package wb_resv_pkg;

    // Width needed to index a selector over n candidates (at least 1 bit).
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wb_busy_shifter.sv
// Busy vector register: shifts toward bit 0 each clock and ORs in new claims.
// Assumes set_mask is already aligned to the post-shift positions.
module wb_busy_shifter #(
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] set_mask,
    output logic [DEPTH-1:0] busy
);

    // Advance time by one bus cycle and record any accepted claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            busy <= {1'b0, busy[DEPTH-1:1]} | set_mask;
        end
    end

endmodule

// File: rtl/wb_slot_probe.sv
// Checks one candidate: is the bus free in the cycle it would write back?
// Assumes a latency of 0 or of DEPTH and above cannot be served.
module wb_slot_probe #(
    parameter int DEPTH = 32,
    parameter int LAT_W = 5
) (
    input  logic [DEPTH-1:0] busy,
    input  logic             valid,
    input  logic [LAT_W-1:0] lat,
    output logic             free
);

    // Select the busy bit at the completion slot; unmatched latencies stay refused.
    always_comb begin
        free = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            if (lat == LAT_W'(k)) begin
                free = valid & ~busy[k];
            end
        end
    end

endmodule

// File: rtl/wb_reserve_decode.sv
// Turns an accepted, granted candidate into a one-hot claim at bit L-1.
// Assumes grant already excludes latencies outside 1..DEPTH-1.
module wb_reserve_decode #(
    parameter int DEPTH = 32,
    parameter int LAT_W = 5,
    parameter int NCAND = 2,
    parameter int SEL_W = 1
) (
    input  logic                   issue_accept,
    input  logic [SEL_W-1:0]       issue_sel,
    input  logic [NCAND-1:0]       grant,
    input  logic [NCAND*LAT_W-1:0] lat_flat,
    output logic [DEPTH-1:0]       set_mask
);

    logic             pick_ok;
    logic [LAT_W-1:0] pick_lat;

    // Pick the selected candidate's grant and latency.
    always_comb begin
        pick_ok  = 1'b0;
        pick_lat = '0;
        for (int c = 0; c < NCAND; c++) begin
            if (issue_sel == SEL_W'(c)) begin
                pick_ok  = grant[c];
                pick_lat = lat_flat[c*LAT_W +: LAT_W];
            end
        end
    end

    // One claim bit per post-shift slot, matched against the chosen latency.
    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_claim
        assign set_mask[k] = issue_accept & pick_ok & (pick_lat == LAT_W'(k + 1));
    end
    assign set_mask[DEPTH-1] = 1'b0;

endmodule

// File: rtl/wb_resv_table.sv
// Top of the writeback reservation table: probes per candidate, decode, shifter.
// Assumes all candidates have fixed latencies known at issue.
module wb_resv_table #(
    parameter  int DEPTH = 32,
    parameter  int NCAND = 2,
    localparam int LAT_W = $clog2(DEPTH),
    localparam int SEL_W = wb_resv_pkg::sel_width(NCAND)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCAND-1:0]       cand_valid,
    input  logic [NCAND*LAT_W-1:0] cand_lat,
    input  logic                   issue_accept,
    input  logic [SEL_W-1:0]       issue_sel,
    output logic [NCAND-1:0]       cand_grant,
    output logic [DEPTH-1:0]       busy_vec
);

    logic [DEPTH-1:0] set_mask;

    for (genvar c = 0; c < NCAND; c++) begin : g_probe
        wb_slot_probe #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_probe (
            .busy  (busy_vec),
            .valid (cand_valid[c]),
            .lat   (cand_lat[c*LAT_W +: LAT_W]),
            .free  (cand_grant[c])
        );
    end

    wb_reserve_decode #(
        .DEPTH(DEPTH), .LAT_W(LAT_W), .NCAND(NCAND), .SEL_W(SEL_W)
    ) u_decode (
        .issue_accept (issue_accept),
        .issue_sel    (issue_sel),
        .grant        (cand_grant),
        .lat_flat     (cand_lat),
        .set_mask     (set_mask)
    );

    wb_busy_shifter #(.DEPTH(DEPTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .busy     (busy_vec)
    );

endmodule

// File: rtl/wb_resv_checker.sv
// Protocol checks for wb_resv_table, attached with bind.
module wb_resv_checker #(
    parameter int DEPTH = 32,
    parameter int NCAND = 2,
    parameter int LAT_W = 5,
    parameter int SEL_W = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCAND-1:0]       cand_valid,
    input logic [NCAND*LAT_W-1:0] cand_lat,
    input logic                   issue_accept,
    input logic [SEL_W-1:0]       issue_sel,
    input logic [NCAND-1:0]       cand_grant,
    input logic [DEPTH-1:0]       busy_vec
);

    logic             sel_granted;
    logic [DEPTH-1:0] exp_claim;

    // Expected claim of the selected candidate, built independently here.
    always_comb begin
        sel_granted = 1'b0;
        exp_claim   = '0;
        for (int c = 0; c < NCAND; c++) begin
            if (int'(issue_sel) == c && cand_grant[c]) begin
                sel_granted = 1'b1;
                exp_claim   = DEPTH'(1) << (int'(cand_lat[c*LAT_W +: LAT_W]) - 1);
            end
        end
    end

    // R1: reset empties the table
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> busy_vec == '0);

    // R3: older claims move down one slot and are never lost
    p_shift_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(busy_vec) >> 1) & ~busy_vec) == '0));

    // R4: an accepted grant holds its completion slot
    p_claim_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_accept && sel_granted) |=> ((busy_vec & $past(exp_claim)) == $past(exp_claim)));

    // R5: without an accepted grant, the vector only shifts
    p_no_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_accept && sel_granted) |=> busy_vec == ($past(busy_vec) >> 1));

    // R5: at most one new bit per edge
    p_one_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $countones(busy_vec) <= $countones($past(busy_vec) >> 1) + 1);

    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        // R2: no grant without a valid candidate
        p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cand_grant[c] |-> cand_valid[c]);
        // R6: latency 0 is refused
        p_lat0_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_lat[c*LAT_W +: LAT_W] == '0) |-> !cand_grant[c]);
    end

endmodule

bind wb_resv_table wb_resv_checker #(
    .DEPTH(DEPTH), .NCAND(NCAND), .LAT_W(LAT_W), .SEL_W(SEL_W)
) u_resv_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cand_valid   (cand_valid),
    .cand_lat     (cand_lat),
    .issue_accept (issue_accept),
    .issue_sel    (issue_sel),
    .cand_grant   (cand_grant),
    .busy_vec     (busy_vec)
);

// File: tb/tb_wb_resv_table.sv
module tb_wb_resv_table;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int NCAND = 2;
    localparam int LAT_W = $clog2(DEPTH);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NCAND-1:0]       cand_valid = '0;
    logic [NCAND*LAT_W-1:0] cand_lat = '0;
    logic                   issue_accept = 1'b0;
    logic [0:0]             issue_sel = '0;
    logic [NCAND-1:0]       cand_grant;
    logic [DEPTH-1:0]       busy_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model[$];
    logic [NCAND-1:0] last_grant;
    int seed = 12345;

    wb_resv_table #(.DEPTH(DEPTH), .NCAND(NCAND)) dut (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_lat(cand_lat),
        .issue_accept(issue_accept), .issue_sel(issue_sel),
        .cand_grant(cand_grant), .busy_vec(busy_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DEPTH-1:0] model_vec();
        logic [DEPTH-1:0] v = '0;
        for (int k = 0; k < DEPTH; k++) v[k] = model[k];
        return v;
    endfunction

    function automatic bit exp_grant(bit v, int l);
        return v && l >= 1 && l < DEPTH && !model[l];
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare, advance the model at posedge.
    task automatic step(bit v0, int l0, bit v1, int l1, bit acc, int sel);
        logic [NCAND-1:0] eg;
        cand_valid   = {v1, v0};
        cand_lat     = {LAT_W'(l1), LAT_W'(l0)};
        issue_accept = acc;
        issue_sel    = 1'(sel);
        #1;
        eg = {exp_grant(v1, l1), exp_grant(v0, l0)};
        if (rst_n) begin
            check(busy_vec == model_vec(), "R3 busy", 64'(busy_vec), 64'(model_vec()));
            check(cand_grant == eg, "R2 grant", 64'(cand_grant), 64'(eg));
        end
        last_grant = cand_grant;
        @(posedge clk);
        if (!rst_n) begin
            foreach (model[k]) model[k] = 0;
        end else begin
            void'(model.pop_front());
            model.push_back(0);
            if (acc && eg[sel]) model[(sel ? l1 : l0) - 1] = 1;
        end
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) model.push_back(0);
        @(negedge clk);
        // R1: accept during reset reserves nothing
        step(1, 7, 0, 0, 1, 0);
        step(1, 9, 0, 0, 1, 0);
        rst_n = 1'b1;
        check(busy_vec == '0, "R1 reset clear", 64'(busy_vec), 0);

        // R9: multiply 10 then four adds of 5, sixth refused
        step(1, 10, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) begin
            step(1, 5, 0, 0, 1, 0);
            check(last_grant[0] == 1'b1, "R9 add granted", 64'(last_grant), 1);
        end
        step(1, 5, 0, 0, 1, 0);
        check(last_grant[0] == 1'b0, "R9 add refused", 64'(last_grant), 0);
        // R5: refused accept left only the shifted claims (cycles 6..10 -> bits 0..4)
        check(busy_vec == DEPTH'(32'h1F), "R5 refused accept", 64'(busy_vec), 64'h1F);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0);

        // R7: two candidates granted together, only the selected one claims
        step(1, 10, 1, 20, 1, 1);
        check(last_grant == 2'b11, "R7 both granted", 64'(last_grant), 3);
        check(busy_vec[19] && !busy_vec[9], "R7 only selected", 64'(busy_vec), 64'h80000);

        // R6: latency 0 refused even with an accept
        step(1, 0, 0, 0, 1, 0);
        check(last_grant[0] == 1'b0, "R6 lat0", 64'(last_grant), 0);

        // R8: longest latency reserved at the top
        step(0, 0, 1, DEPTH-1, 1, 1);
        check(busy_vec[DEPTH-2] == 1'b1, "R8 top slot", 64'(busy_vec), 64'(1) << (DEPTH-2));

        // R5: grant present but no accept
        step(1, 3, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check(busy_vec[1] == 1'b0, "R5 no accept", 64'(busy_vec), 0);

        // R4: exact slot after an accept
        step(1, 2, 0, 0, 1, 0);
        check(busy_vec[1] == 1'b1, "R4 claim slot", 64'(busy_vec), 2);

        // Mixed traffic, compared to the model every clock
        for (int i = 0; i < 400; i++) begin
            int a, b;
            seed = seed * 1103515245 + 12345;
            a = (seed >>> 8) & 31;
            b = (seed >>> 14) & 31;
            step(seed[20], a, seed[21], b, seed[22] | seed[23], int'(seed[24]));
        end

        // R1: mid-run reset empties the table
        rst_n = 1'b0;
        step(1, 4, 1, 6, 1, 0);
        rst_n = 1'b1;
        check(busy_vec == '0, "R1 mid reset", 64'(busy_vec), 0);
        step(0, 0, 0, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule